// File: doc/BRIEF.md
# Floating-Point Mantissa Rounding Unit

This block rounds an extended floating-point mantissa to its kept width. The input carries the kept mantissa bits with two extra low-order bits beneath them, a guard bit and then a round bit. A separate sticky bit reports whether anything non-zero was shifted out further below. The sign and a 2-bit rounding-mode field select the rule.

The rounding path is purely combinational. It drops guard and round, adds one when the selected rule asks for it, and presents the kept mantissa, a carry-out and a rounded-up indication in the same cycle. When every kept bit is one and an increment occurs, the carry-out signals a value one bit wider. Renormalising it and adjusting the exponent are left to the consumer.

Alongside the result, three status bits collect events across operations: inexact, fraction-inexact and fraction-rounded. Once set, each stays set until the clear input is pulsed. Each is loaded from the inputs present at each rising clock edge.

Top module: `fp_mant_rounder`

## Requirements
- R1: When no increment is applied, `o_mant` equals `i_mant` shifted right by two (guard in bit 1 and round in bit 0 are discarded), and `o_carry` is 0.
- R2: When guard, round and sticky are all 0, the result is exact: `o_up` is 0 and `o_inexact` is 0.
- R3: When any of guard, round or sticky is 1, `o_inexact` is 1. At the next rising edge, both `stat_inexact` and `stat_frac_inexact` become 1.
- R4: With `i_mode` = 2'b00 (nearest), an increment happens only if guard is 1 and at least one of round, sticky or the kept LSB is 1. An exact tie therefore rounds to even.
- R5: With `i_mode` = 2'b01 (toward zero), no increment ever happens.
- R6: With `i_mode` = 2'b10 (toward +infinity), an inexact value is incremented only when `i_sign` is 0. With `i_mode` = 2'b11 (toward -infinity), an inexact value is incremented only when `i_sign` is 1.
- R7: Whenever an increment happens, `o_up` is 1 and `{o_carry, o_mant}` equals the kept mantissa plus one. At the next rising edge, `stat_frac_rnd` becomes 1.
- R8: Incrementing an all-ones kept mantissa gives `o_mant` = 0 with `o_carry` = 1.
- R9: The status bits are 0 after reset. Once set, each stays 1 while `i_stat_clr` is 0, whatever the later inputs are.
- R10: If `i_stat_clr` is 1 at a rising edge, all status bits are 0 after that edge, even when the current inputs are inexact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Active-low synchronous reset of the status bits |
| i_mant | input | MANT_W+2 | Kept mantissa above guard (bit 1) and round (bit 0) |
| i_sticky | input | 1 | OR of all bits below the round bit |
| i_sign | input | 1 | Sign of the value, 1 = negative |
| i_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| i_stat_clr | input | 1 | Clears the status bits at the next rising edge |
| o_mant | output | MANT_W | Rounded kept mantissa |
| o_carry | output | 1 | Carry out of the increment |
| o_up | output | 1 | An increment was applied |
| o_inexact | output | 1 | Guard, round or sticky was set |
| stat_inexact | output | 1 | Accumulated inexact |
| stat_frac_inexact | output | 1 | Accumulated fraction-inexact |
| stat_frac_rnd | output | 1 | Accumulated fraction-rounded |

## Verification
The assertions assume that `i_mant`, `i_sticky`, `i_sign` and `i_mode` do not change near a rising edge. They also assume `i_sticky` really summarises the bits below the round bit, so that any combination of the three low bits is legal. The stimulus changes every input on the falling edge only. It reads the combinational results just before the next rising edge and reads the status bits just after that edge. Because every mode code and every guard/round/sticky pattern the rules care about is legal, the vector table uses them freely. This includes an all-ones kept mantissa, which drives the carry-out.

// File: rtl/fp_mant_rounder.sv
module fp_mant_rounder #(
  parameter int MANT_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MANT_W+1:0] i_mant,
  input  logic              i_sticky,
  input  logic              i_sign,
  input  logic [1:0]        i_mode,
  input  logic              i_stat_clr,
  output logic [MANT_W-1:0] o_mant,
  output logic              o_carry,
  output logic              o_up,
  output logic              o_inexact,
  output logic              stat_inexact,
  output logic              stat_frac_inexact,
  output logic              stat_frac_rnd
);

  localparam logic [1:0] MODE_NEAR = 2'b00;
  localparam logic [1:0] MODE_ZERO = 2'b01;
  localparam logic [1:0] MODE_PINF = 2'b10;
  localparam logic [1:0] MODE_MINF = 2'b11;

  logic [MANT_W-1:0] kept;
  logic              guard, rbit, lost, inc;

  assign kept  = i_mant[MANT_W+1:2];
  assign guard = i_mant[1];
  assign rbit  = i_mant[0];
  assign lost  = guard | rbit | i_sticky;

  always_comb begin
    unique case (i_mode)
      MODE_NEAR: inc = guard & (rbit | i_sticky | kept[0]);
      MODE_ZERO: inc = 1'b0;
      MODE_PINF: inc = lost & ~i_sign;
      MODE_MINF: inc = lost & i_sign;
      default:   inc = 1'b0;
    endcase
  end

  assign {o_carry, o_mant} = {1'b0, kept} + {{MANT_W{1'b0}}, inc};
  assign o_up      = inc;
  assign o_inexact = lost;

  always_ff @(posedge clk) begin
    if (!rst_n || i_stat_clr) begin
      stat_inexact      <= 1'b0;
      stat_frac_inexact <= 1'b0;
      stat_frac_rnd     <= 1'b0;
    end else begin
      stat_inexact      <= stat_inexact | lost;
      stat_frac_inexact <= stat_frac_inexact | lost;
      stat_frac_rnd     <= stat_frac_rnd | inc;
    end
  end

  AST_TRUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !o_up |-> (o_mant == i_mant[MANT_W+1:2]) && !o_carry); // R1
  AST_EXACT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (i_mant[1:0] == 2'b00 && !i_sticky) |-> !o_up && !o_inexact); // R2
  AST_NEAR_NEEDS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (i_mode == 2'b00 && !i_mant[1]) |-> !o_up); // R4
  AST_RZ_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (i_mode == 2'b01) |-> !o_up); // R5
  AST_DIR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ((i_mode == 2'b10 && i_sign) || (i_mode == 2'b11 && !i_sign)) |-> !o_up); // R6
  AST_INC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    o_up |-> ({o_carry, o_mant} == {1'b0, i_mant[MANT_W+1:2]} + 1'b1)); // R7
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_frac_rnd && !i_stat_clr) |=> stat_frac_rnd); // R9
  AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    i_stat_clr |=> !stat_inexact && !stat_frac_inexact && !stat_frac_rnd); // R10

endmodule

// File: tb/test_fp_mant_rounder.sv
module test_fp_mant_rounder;
  localparam int W = 26;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  typedef struct packed {
    logic [3:0]   req;
    logic [W-1:0] kept;
    logic [1:0]   gr;
    logic         stk;
    logic         sgn;
    logic [1:0]   mode;
    logic [W-1:0] e_mant;
    logic         e_carry;
    logic         e_up;
    logic         e_inx;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 26'd5, 2'b00, 1'b0, 1'b0, 2'b00, 26'd5, 1'b0, 1'b0, 1'b0}, // R2 exact
    '{4'd4, 26'd5, 2'b10, 1'b0, 1'b0, 2'b00, 26'd6, 1'b0, 1'b1, 1'b1}, // R4 tie odd
    '{4'd4, 26'd4, 2'b10, 1'b0, 1'b0, 2'b00, 26'd4, 1'b0, 1'b0, 1'b1}, // R4 tie even
    '{4'd4, 26'd4, 2'b10, 1'b1, 1'b0, 2'b00, 26'd5, 1'b0, 1'b1, 1'b1}, // R4 sticky
    '{4'd4, 26'd4, 2'b11, 1'b0, 1'b1, 2'b00, 26'd5, 1'b0, 1'b1, 1'b1}, // R4 round bit
    '{4'd3, 26'd4, 2'b01, 1'b1, 1'b0, 2'b00, 26'd4, 1'b0, 1'b0, 1'b1}, // R3 no guard
    '{4'd5, 26'd7, 2'b11, 1'b1, 1'b0, 2'b01, 26'd7, 1'b0, 1'b0, 1'b1}, // R5
    '{4'd6, 26'd7, 2'b01, 1'b0, 1'b0, 2'b10, 26'd8, 1'b0, 1'b1, 1'b1}, // R6 +inf pos
    '{4'd6, 26'd7, 2'b01, 1'b0, 1'b1, 2'b10, 26'd7, 1'b0, 1'b0, 1'b1}, // R6 +inf neg
    '{4'd6, 26'd7, 2'b00, 1'b1, 1'b1, 2'b11, 26'd8, 1'b0, 1'b1, 1'b1}, // R6 -inf neg
    '{4'd6, 26'd7, 2'b10, 1'b0, 1'b0, 2'b11, 26'd7, 1'b0, 1'b0, 1'b1}, // R6 -inf pos
    '{4'd8, ONES,  2'b11, 1'b0, 1'b0, 2'b00, 26'd0, 1'b1, 1'b1, 1'b1}, // R8
    '{4'd1, ONES,  2'b00, 1'b0, 1'b0, 2'b10, ONES,  1'b0, 1'b0, 1'b0}, // R1
    '{4'd7, 26'h2AAAAAA, 2'b00, 1'b1, 1'b0, 2'b10, 26'h2AAAAAB, 1'b0, 1'b1, 1'b1} // R7
  };

  logic clk = 0, rst_n = 0, sticky = 0, sign = 0, clr = 0;
  logic [W+1:0] mant = '0;
  logic [1:0] mode = '0;
  logic [W-1:0] o_mant;
  logic o_carry, o_up, o_inexact, s_inx, s_fi, s_fr;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  fp_mant_rounder #(.MANT_W(W)) i_fp_mant_rounder (
    .clk(clk), .rst_n(rst_n), .i_mant(mant), .i_sticky(sticky), .i_sign(sign),
    .i_mode(mode), .i_stat_clr(clr), .o_mant(o_mant), .o_carry(o_carry),
    .o_up(o_up), .o_inexact(o_inexact), .stat_inexact(s_inx),
    .stat_frac_inexact(s_fi), .stat_frac_rnd(s_fr));

  task automatic chk(input string tag, input logic [W+2:0] act, input logic [W+2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] k, input logic [1:0] gr, input logic s,
                       input logic sg, input logic [1:0] md, input logic c);
    @(negedge clk);
    mant = {k, gr}; sticky = s; sign = sg; mode = md; clr = c;
  endtask

  task automatic stat_chk(input string tag, input logic [2:0] exp);
    @(posedge clk); #1;
    chk(tag, {{W{1'b0}}, s_inx, s_fi, s_fr}, {{W{1'b0}}, exp});
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset status", {{W{1'b0}}, s_inx, s_fi, s_fr}, '0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].kept, VEC[i].gr, VEC[i].stk, VEC[i].sgn, VEC[i].mode, 1'b1);
      #1;
      chk($sformatf("R%0d vec%0d", VEC[i].req, i),
          {o_mant, o_carry, o_up, o_inexact},
          {VEC[i].e_mant, VEC[i].e_carry, VEC[i].e_up, VEC[i].e_inx});
    end

    // R10 clear with inexact inputs present
    drive(26'd4, 2'b11, 1'b1, 1'b0, 2'b00, 1'b1);
    stat_chk("R10 clear wins", 3'b000);
    // R2 exact input leaves status clear
    drive(26'd9, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0);
    stat_chk("R2 exact status", 3'b000);
    // R3 inexact without increment (toward zero)
    drive(26'd9, 2'b10, 1'b0, 1'b0, 2'b01, 1'b0);
    stat_chk("R3 inexact status", 3'b110);
    // R7 increment sets rounded flag
    drive(26'd9, 2'b01, 1'b0, 1'b0, 2'b10, 1'b0);
    stat_chk("R7 rounded status", 3'b111);
    // R9 sticky through exact inputs
    drive(26'd9, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0);
    stat_chk("R9 hold", 3'b111);
    stat_chk("R9 hold again", 3'b111);
    // R10 plain clear
    drive(26'd9, 2'b00, 1'b0, 1'b0, 2'b00, 1'b1);
    stat_chk("R10 clear", 3'b000);
    drive(26'd9, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule